// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns a 32-bit linear address into a physical address. It walks a two-level table held in memory: a directory whose frame number comes from a root input, then a page table that the selected directory entry points to. A small, fully associative cache of translations sits in front of the walk, so a hit needs no table read. A control input can disable paging. In that case every address passes through unchanged and no table is touched.

A requester hands over one address at a time with a valid/ready handshake and gets back a one-cycle response. The response carries either the physical address or a fault flag. A fault happens when an entry is absent or when a user-mode access reaches a page reserved for supervisor code. The faulting linear address is kept in a register until the next fault. Table entries are fetched through a simple read port: the block holds a read request until memory returns one data beat. Loading a different directory frame number, as happens on a switch of address space, empties the translation cache.

Top module: `xlate_unit`

## Requirements
- R1: With `paging_en_i` low, an accepted request returns `rsp_paddr_o` equal to the request address, with no fault and no memory read, whatever the mode bit.
- R2: With paging on, the directory entry is read from {root frame, address[31:22], 2'b00}. The table entry is read from {entry[31:12] of the directory entry, address[21:12], 2'b00}. The result is {entry[31:12] of the table entry, address[11:0]}.
- R3: Bit 0 of an entry means present. A directory entry with bit 0 clear faults after one read. A table entry with bit 0 clear faults after two reads.
- R4: Bit 2 of an entry means user-accessible. A user access (`req_user_i`=1) faults if bit 2 is clear at either level. A supervisor access ignores bit 2.
- R5: On every fault, `fault_addr_o` takes the faulting linear address. It keeps that value through later successful translations.
- R6: A translation already in the cache returns the same physical address with no memory read.
- R7: Only a walk that completes without a fault fills the cache. Repeating a faulting address walks again.
- R8: A change of `dir_base_i` invalidates every cached translation, so the next access walks using the new root.
- R9: The cache holds 8 translations and replaces them in round-robin order starting at slot 0. The ninth distinct fill evicts the first translation, and the tenth evicts the second.
- R10: `req_ready_o` is low from the cycle after acceptance until the response. `rsp_valid_o` is high for exactly one cycle per accepted request.
- R11: After reset, `rsp_valid_o`, `mem_req_o` and `fault_addr_o` are zero and the unit accepts requests.
- R12: A cached translation filled by a supervisor walk to a supervisor-only page makes a later user access to that page fault with no memory read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en_i | input | 1 | 1 = translate, 0 = pass addresses through |
| dir_base_i | input | 20 | Frame number of the top-level directory |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_addr_i | input | 32 | Linear address to translate |
| req_user_i | input | 1 | 1 = user-mode access |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Response is a fault |
| fault_addr_o | output | 32 | Linear address of the most recent fault |
| mem_req_o | output | 1 | Table entry read request, held until data returns |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid (one beat per request) |
| mem_rdata_i | input | 32 | Read data: the table entry |

## Verification
The assertions assume that memory returns exactly one `mem_rvalid_i` beat for each request, and only while `mem_req_o` is high. They also assume that `dir_base_i` changes only while the unit is idle. The bench's memory model answers each held request once, after a fixed delay, and starts the next read only after the beat has been consumed. The bench changes the root only between transactions, after the previous response has been checked. Requests are raised one at a time and held until the handshake completes, which matches the single-outstanding-request behaviour the response checks rely on.

// File: rtl/xlate_pkg.sv
// Shared definitions for the page translation unit.
// Assumes entries carry the frame number in their top bits, with flag bits at fixed low positions.
package xlate_pkg;

    // Walk controller states
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_PDE = 3'd1,
        ST_FETCH_PTE = 3'd2,
        ST_DONE      = 3'd3,
        ST_FAULT     = 3'd4
    } walk_state_e;

    // Flag bit positions inside a directory or table entry
    localparam int unsigned ENT_PRESENT_BIT = 0;
    localparam int unsigned ENT_USER_BIT    = 2;

endpackage

// File: rtl/xlate_root.sv
// Holds the directory root frame number and reports when the input value changes.
// Assumes the root changes only while the walk controller is idle.
module xlate_root #(
    parameter int unsigned PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_i,
    output logic [PPN_W-1:0] root_q_o,
    output logic             change_o
);

    logic [PPN_W-1:0] root_q;

    // Register the root so a change shows for one cycle before it takes effect
    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= '0;
        else        root_q <= root_i;
    end

    // Flag a pending root update
    always_comb begin
        change_o = (root_i != root_q);
        root_q_o = root_q;
    end

endmodule

// File: rtl/xlate_tlb.sv
// Fully associative translation cache with round-robin replacement.
// Assumes fills come only for page numbers that missed, so no entry is duplicated.
module xlate_tlb #(
    parameter int unsigned VPN_W = 20,
    parameter int unsigned PPN_W = 20,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] look_vpn_i,
    output logic             hit_o,
    output logic [PPN_W-1:0] hit_ppn_o,
    output logic             hit_uok_o,
    input  logic             fill_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             fill_uok_i
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] valid_q;
    logic [VPN_W-1:0] vpn_q [DEPTH];
    logic [PPN_W-1:0] ppn_q [DEPTH];
    logic [DEPTH-1:0] uok_q;
    logic [PTR_W-1:0] ptr_q;
    logic [DEPTH-1:0] hit_vec;

    // Per-slot tag comparators
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign hit_vec[s] = valid_q[s] && (vpn_q[s] == look_vpn_i);
    end

    // OR-combine the matching slot onto the outputs
    always_comb begin
        hit_ppn_o = '0;
        hit_uok_o = 1'b0;
        for (int s = 0; s < DEPTH; s++) begin
            if (hit_vec[s]) begin
                hit_ppn_o = hit_ppn_o | ppn_q[s];
                hit_uok_o = hit_uok_o | uok_q[s];
            end
        end
        hit_o = |hit_vec;
    end

    // Valid bits and replacement pointer: flush wins over fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (fill_i) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
        end
    end

    // Slot payload storage, written at the replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uok_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                vpn_q[s] <= '0;
                ppn_q[s] <= '0;
            end
        end else if (fill_i && !flush_i) begin
            vpn_q[ptr_q] <= fill_vpn_i;
            ppn_q[ptr_q] <= fill_ppn_i;
            uok_q[ptr_q] <= fill_uok_i;
        end
    end

    // R9
    tlb_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8
    tlb_flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

endmodule

// File: rtl/xlate_walker.sv
// Request handshake and two-level table walk controller.
// Assumes one read beat per held memory request and OFF_W == IDX_W + 2 (one table per frame).
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    paging_en_i,
    input  logic [ADDR_W-OFF_W-1:0] root_ppn_i,
    input  logic                    hold_i,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    req_user_i,
    input  logic                    tlb_hit_i,
    input  logic [ADDR_W-OFF_W-1:0] tlb_ppn_i,
    input  logic                    tlb_uok_i,
    output logic                    tlb_fill_o,
    output logic [ADDR_W-OFF_W-1:0] tlb_fill_vpn_o,
    output logic [ADDR_W-OFF_W-1:0] tlb_fill_ppn_o,
    output logic                    tlb_fill_uok_o,
    output logic                    mem_req_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    input  logic                    mem_rvalid_i,
    input  logic [ADDR_W-1:0]       mem_rdata_i,
    output logic                    rsp_valid_o,
    output logic [ADDR_W-1:0]       rsp_paddr_o,
    output logic                    rsp_fault_o,
    output logic [ADDR_W-1:0]       fault_addr_o
);

    localparam int unsigned PN_W   = ADDR_W - OFF_W;
    localparam int unsigned DIR_HI = ADDR_W - 1;
    localparam int unsigned DIR_LO = ADDR_W - IDX_W;
    localparam int unsigned TBL_HI = DIR_LO - 1;
    localparam int unsigned TBL_LO = OFF_W;
    localparam int unsigned PAD_W  = OFF_W - IDX_W;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              user_q;
    logic [PN_W-1:0]   tbl_ppn_q;
    logic              dir_uok_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] fault_addr_q;

    logic accept;
    logic ent_present;
    logic ent_user;
    logic ent_deny;

    // Handshake and decode of the returning entry
    always_comb begin
        req_ready_o = (state_q == ST_IDLE) && !hold_i;
        accept      = req_valid_i && req_ready_o;
        ent_present = mem_rdata_i[ENT_PRESENT_BIT];
        ent_user    = mem_rdata_i[ENT_USER_BIT];
        ent_deny    = !ent_present || (user_q && !ent_user);
    end

    // Table read address for the current walk level
    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
        if (state_q == ST_FETCH_PDE) begin
            mem_req_o  = 1'b1;
            mem_addr_o = {root_ppn_i, addr_q[DIR_HI:DIR_LO], {PAD_W{1'b0}}};
        end else if (state_q == ST_FETCH_PTE) begin
            mem_req_o  = 1'b1;
            mem_addr_o = {tbl_ppn_q, addr_q[TBL_HI:TBL_LO], {PAD_W{1'b0}}};
        end
    end

    // Cache fill after a clean second-level read
    always_comb begin
        tlb_fill_o     = (state_q == ST_FETCH_PTE) && mem_rvalid_i && !ent_deny;
        tlb_fill_vpn_o = addr_q[ADDR_W-1:OFF_W];
        tlb_fill_ppn_o = mem_rdata_i[ADDR_W-1:OFF_W];
        tlb_fill_uok_o = dir_uok_q && ent_user;
    end

    // Walk state machine with result and fault-address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            user_q       <= 1'b0;
            tbl_ppn_q    <= '0;
            dir_uok_q    <= 1'b0;
            paddr_q      <= '0;
            fault_addr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q <= req_addr_i;
                        user_q <= req_user_i;
                        if (!paging_en_i) begin
                            paddr_q <= req_addr_i;
                            state_q <= ST_DONE;
                        end else if (tlb_hit_i) begin
                            if (req_user_i && !tlb_uok_i) begin
                                paddr_q      <= '0;
                                fault_addr_q <= req_addr_i;
                                state_q      <= ST_FAULT;
                            end else begin
                                paddr_q <= {tlb_ppn_i, req_addr_i[OFF_W-1:0]};
                                state_q <= ST_DONE;
                            end
                        end else begin
                            state_q <= ST_FETCH_PDE;
                        end
                    end
                end
                ST_FETCH_PDE: begin
                    if (mem_rvalid_i) begin
                        if (ent_deny) begin
                            paddr_q      <= '0;
                            fault_addr_q <= addr_q;
                            state_q      <= ST_FAULT;
                        end else begin
                            tbl_ppn_q <= mem_rdata_i[ADDR_W-1:OFF_W];
                            dir_uok_q <= ent_user;
                            state_q   <= ST_FETCH_PTE;
                        end
                    end
                end
                ST_FETCH_PTE: begin
                    if (mem_rvalid_i) begin
                        if (ent_deny) begin
                            paddr_q      <= '0;
                            fault_addr_q <= addr_q;
                            state_q      <= ST_FAULT;
                        end else begin
                            paddr_q <= {mem_rdata_i[ADDR_W-1:OFF_W], addr_q[OFF_W-1:0]};
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FAULT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Response drive
    always_comb begin
        rsp_valid_o  = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_fault_o  = (state_q == ST_FAULT);
        rsp_paddr_o  = paddr_q;
        fault_addr_o = fault_addr_q;
    end

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !paging_en_i) |=>
            (rsp_valid_o && !rsp_fault_o && rsp_paddr_o == $past(req_addr_i)));

    // R10
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready_o);

    // R5
    fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_fault_o) |=> $stable(fault_addr_o));

    // R7
    fill_means_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_fill_o |=> (rsp_valid_o && !rsp_fault_o));

    // R6
    mem_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);

endmodule

// File: rtl/xlate_unit.sv
// Top of the page translation unit: root tracker, translation cache and walk controller.
// Assumes the requester keeps one request outstanding and changes the root only while idle.
module xlate_unit #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned TLB_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    paging_en_i,
    input  logic [ADDR_W-OFF_W-1:0] dir_base_i,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic                    req_user_i,
    output logic                    rsp_valid_o,
    output logic [ADDR_W-1:0]       rsp_paddr_o,
    output logic                    rsp_fault_o,
    output logic [ADDR_W-1:0]       fault_addr_o,
    output logic                    mem_req_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    input  logic                    mem_rvalid_i,
    input  logic [ADDR_W-1:0]       mem_rdata_i
);

    localparam int unsigned PN_W = ADDR_W - OFF_W;

    logic [PN_W-1:0] root_ppn;
    logic            root_change;
    logic            hit;
    logic [PN_W-1:0] hit_ppn;
    logic            hit_uok;
    logic            fill;
    logic [PN_W-1:0] fill_vpn;
    logic [PN_W-1:0] fill_ppn;
    logic            fill_uok;

    xlate_root #(.PPN_W(PN_W)) u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .root_i   (dir_base_i),
        .root_q_o (root_ppn),
        .change_o (root_change)
    );

    xlate_tlb #(.VPN_W(PN_W), .PPN_W(PN_W), .DEPTH(TLB_DEPTH)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (root_change),
        .look_vpn_i (req_addr_i[ADDR_W-1:OFF_W]),
        .hit_o      (hit),
        .hit_ppn_o  (hit_ppn),
        .hit_uok_o  (hit_uok),
        .fill_i     (fill),
        .fill_vpn_i (fill_vpn),
        .fill_ppn_i (fill_ppn),
        .fill_uok_i (fill_uok)
    );

    xlate_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .paging_en_i    (paging_en_i),
        .root_ppn_i     (root_ppn),
        .hold_i         (root_change),
        .req_valid_i    (req_valid_i),
        .req_ready_o    (req_ready_o),
        .req_addr_i     (req_addr_i),
        .req_user_i     (req_user_i),
        .tlb_hit_i      (hit),
        .tlb_ppn_i      (hit_ppn),
        .tlb_uok_i      (hit_uok),
        .tlb_fill_o     (fill),
        .tlb_fill_vpn_o (fill_vpn),
        .tlb_fill_ppn_o (fill_ppn),
        .tlb_fill_uok_o (fill_uok),
        .mem_req_o      (mem_req_o),
        .mem_addr_o     (mem_addr_o),
        .mem_rvalid_i   (mem_rvalid_i),
        .mem_rdata_i    (mem_rdata_i),
        .rsp_valid_o    (rsp_valid_o),
        .rsp_paddr_o    (rsp_paddr_o),
        .rsp_fault_o    (rsp_fault_o),
        .fault_addr_o   (fault_addr_o)
    );

    // R11
    idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_o);

endmodule

// File: tb/xlate_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expectations, the monitor checks each response.
module xlate_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [19:0] dir_base = 20'h00100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [31:0] fault_addr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int mem_reads = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] va;
        logic        fault;
        logic [31:0] paddr;
        int          reads;
        int          reads_before;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [31:0] mem [int unsigned];

    always #2.5 clk = ~clk;

    xlate_unit u_xlate_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .paging_en_i  (paging_en),
        .dir_base_i   (dir_base),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_addr_i   (req_addr),
        .req_user_i   (req_user),
        .rsp_valid_o  (rsp_valid),
        .rsp_paddr_o  (rsp_paddr),
        .rsp_fault_o  (rsp_fault),
        .fault_addr_o (fault_addr),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
    endfunction

    // Memory model: one beat, two cycles after a request is seen
    int mcnt = 0;
    bit pend = 1'b0;
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (pend) begin
            if (mcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd(mem_addr);
                pend <= 1'b0;
            end else mcnt <= mcnt - 1;
        end else if (mem_req && rst_n) begin
            pend <= 1'b1;
            mcnt <= 1;
            mem_reads <= mem_reads + 1;
        end
    end

    // Writes directory and table entries; table for directory d sits at pt_region + d*4K
    task automatic map(input logic [31:0] root, input logic [31:0] pt_region, input logic [31:0] va,
                       input logic [2:0] pde_fl, input logic [2:0] pte_fl, input logic [31:0] frame);
        logic [31:0] pt;
        pt = pt_region + {va[31:22], 12'h000};
        mem[({root[31:12], va[31:22], 2'b00}) >> 2] = {pt[31:12], 9'h0, pde_fl};
        mem[({pt[31:12], va[21:12], 2'b00}) >> 2]   = {frame[31:12], 9'h0, pte_fl};
    endtask

    // Driver: queue the expectation, then perform the handshake
    task automatic xlate(input logic [31:0] va, input bit user, input bit f,
                         input logic [31:0] pa, input int nreads, input string tag);
        exp_t e;
        e.va = va; e.fault = f; e.paddr = pa; e.reads = nreads;
        e.reads_before = mem_reads; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = va; req_user = user;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready || rsp_valid, {"R10 busy ", tag}, {31'h0, req_ready}, 32'h0);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compare each response against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_fault == e.fault, {e.tag, " fault"}, {31'h0, rsp_fault}, {31'h0, e.fault});
                if (!e.fault)
                    check(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
                else
                    check(fault_addr == e.va, {e.tag, " R5 fault_addr"}, fault_addr, e.va);
                check((mem_reads - e.reads_before) == e.reads, {e.tag, " reads"},
                      mem_reads - e.reads_before, e.reads);
                @(negedge clk);
                check(!rsp_valid, {e.tag, " R10 pulse"}, {31'h0, rsp_valid}, 32'h0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [31:0] ROOT_A = 32'h0010_0000;
    localparam logic [31:0] ROOT_B = 32'h0030_0000;
    localparam logic [31:0] PT_A   = 32'h0020_0000;
    localparam logic [31:0] PT_B   = 32'h0040_0000;

    initial begin
        // Tables under root A
        map(ROOT_A, PT_A, 32'h0040_1abc, 3'h7, 3'h7, 32'h0AB0_0000);
        map(ROOT_A, PT_A, 32'h0080_2000, 3'h7, 3'h3, 32'h0BC0_0000);
        map(ROOT_A, PT_A, 32'h00C0_0000, 3'h3, 3'h7, 32'h0DE0_0000);
        // Tables under root B
        map(ROOT_B, PT_B, 32'h0040_1abc, 3'h7, 3'h7, 32'h0CD0_0000);
        for (int k = 0; k < 8; k++)
            map(ROOT_B, PT_B, 32'h0100_0000 | (k << 12), 3'h7, 3'h7, 32'h1000_0000 + (k << 12));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!rsp_valid, "R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check(!mem_req, "R11 mem_req", {31'h0, mem_req}, 32'h0);
        check(fault_addr == 32'h0, "R11 fault_addr", fault_addr, 32'h0);
        @(negedge clk);
        check(req_ready, "R11 ready", {31'h0, req_ready}, 32'h1);

        // R1 pass-through
        xlate(32'h1234_5678, 1'b1, 1'b0, 32'h1234_5678, 0, "R1 user");
        xlate(32'hFFFF_F004, 1'b0, 1'b0, 32'hFFFF_F004, 0, "R1 sup");

        paging_en = 1'b1;
        // R2 walk, R6 hit
        xlate(32'h0040_1abc, 1'b1, 1'b0, 32'h0AB0_0abc, 2, "R2 walk");
        xlate(32'h0040_1123, 1'b1, 1'b0, 32'h0AB0_0123, 0, "R6 hit");
        // R3 missing directory entry, missing table entry
        xlate(32'h0140_0000, 1'b0, 1'b1, 32'h0, 1, "R3 pde");
        xlate(32'h0040_3000, 1'b0, 1'b1, 32'h0, 2, "R3 pte");
        // R7 a faulting walk is not cached
        xlate(32'h0040_3000, 1'b0, 1'b1, 32'h0, 2, "R7 rewalk");
        // R5 fault address holds across a success
        xlate(32'h0040_1000, 1'b0, 1'b0, 32'h0AB0_0000, 0, "R5 success");
        check(fault_addr == 32'h0040_3000, "R5 hold", fault_addr, 32'h0040_3000);
        // R4 supervisor-only table entry, then supervisor-only directory entry
        xlate(32'h0080_2010, 1'b1, 1'b1, 32'h0, 2, "R4 pte user");
        xlate(32'h00C0_0000, 1'b1, 1'b1, 32'h0, 1, "R4 pde user");
        xlate(32'h0080_2010, 1'b0, 1'b0, 32'h0BC0_0010, 2, "R4 sup");
        // R12 cached supervisor page denies user
        xlate(32'h0080_2020, 1'b1, 1'b1, 32'h0, 0, "R12 cached");

        // R8 root change flushes
        dir_base = ROOT_B[31:12];
        xlate(32'h0040_1abc, 1'b0, 1'b0, 32'h0CD0_0abc, 2, "R8 flush");
        // R9 round robin: va1 in slot 0, fill slots 1..7 then evict slot 0
        for (int k = 0; k < 8; k++)
            xlate(32'h0100_0000 | (k << 12), 1'b0, 1'b0, 32'h1000_0000 + (k << 12), 2, "R9 fill");
        xlate(32'h0040_1abc, 1'b0, 1'b0, 32'h0CD0_0abc, 2, "R9 evicted");
        xlate(32'h0100_1004, 1'b0, 1'b0, 32'h1000_1004, 0, "R9 kept");
        xlate(32'h0100_0008, 1'b0, 1'b0, 32'h1000_0008, 2, "R9 second evicted");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule